// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Manager

This block tracks the consume and refill positions of a circular ring of receive descriptors held in host memory. Software programs a ring base address and a ring length in descriptors. It then hands new buffers to hardware by writing a refill index, which is the slot one past the last valid descriptor. The receive datapath asks whether it may store a packet into the descriptor at the consume index. It reports the store with a strobe, and later reports that the used descriptor has been written back. The consume index moves forward only on that write-back.

The block outputs the byte address of the current descriptor and an empty flag, which is true when the consume index equals the refill index. It also outputs a permission signal that stops packet storage while the ring is empty or while a write-back is outstanding, and a count of descriptors that are ready for use. All inputs are single-cycle strobes sampled on the rising clock edge. All outputs are decoded from registered state, so they reflect a strobe one edge after it is applied.

Top module: `rxr_ring_ptr`

## Requirements
- R1: After reset the consume index, refill index, available count and pending flag are all zero, and the ring reads as empty with store permission low.
- R2: A configuration strobe loads the base address and ring length and zeroes the consume index, the refill index and the pending flag, whatever else is applied in that cycle.
- R3: A refill write whose value is less than the ring length updates the refill index. A value at or above the length leaves the refill index unchanged.
- R4: The empty flag is high exactly when the consume index equals the refill index. While it is high, store permission is low and a store strobe has no effect.
- R5: A store strobe applied while store permission is high sets the pending flag and drops store permission. The consume index holds, and further store strobes are ignored, until the write-back.
- R6: A write-back strobe while pending advances the consume index by one, wrapping from length-1 to 0, and clears the pending flag. A write-back strobe with nothing pending has no effect.
- R7: The descriptor address equals the base address plus 16 times the consume index.
- R8: The available count equals (refill index minus consume index) modulo the ring length. A refill write and a store in the same cycle both take effect.
- R9: When a configuration strobe and a refill write arrive in the same cycle, the refill write is discarded and the refill index reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_size | input | IDX_W+1 | Ring length in descriptors |
| tail_wr | input | 1 | Refill index write strobe |
| tail_val | input | IDX_W | Refill index value |
| store_done | input | 1 | Packet stored into the current descriptor |
| wb_done | input | 1 | Current descriptor written back |
| store_ok | output | 1 | Packet storage permitted |
| wb_pending | output | 1 | Stored descriptor awaiting write-back |
| ring_empty | output | 1 | Consume index equals refill index |
| head_idx | output | IDX_W | Consume index |
| tail_idx | output | IDX_W | Refill index |
| avail_cnt | output | IDX_W | Descriptors ready for use |
| desc_addr | output | ADDR_W | Byte address of the current descriptor |

## Verification
The hardest case to reach is the wrap of the consume index at the largest legal ring length, because the index has to be walked through every slot. The stimulus programs the full length and moves the refill index to the last slot. It then runs store and write-back pairs back to back until the consume index catches up. Finally it moves the refill index to zero, so that a single further advance has to wrap. Coincident strobes also get their own cycles: a configuration strobe with a refill write, a configuration strobe with a write-back, and a store with a refill write.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Wide working type for index arithmetic; modules zero-extend into it.
  typedef logic [16:0] ring_word_t;
  localparam int DESC_SHIFT = 4;

  // Next slot after idx in a ring of len entries.
  function automatic ring_word_t ring_next(ring_word_t idx, ring_word_t len);
    ring_word_t n;
    n = idx + 17'd1;
    return (n >= len) ? 17'd0 : n;
  endfunction

  // Forward distance from frm to to, modulo len.
  function automatic ring_word_t ring_gap(ring_word_t to, ring_word_t frm, ring_word_t len);
    if (to >= frm) return to - frm;
    return (len - frm) + to;
  endfunction

  // Byte address of a descriptor slot.
  function automatic logic [63:0] slot_addr(logic [63:0] base, ring_word_t idx);
    return base + ({47'd0, idx} << DESC_SHIFT);
  endfunction
endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W:0]    cfg_size,
  input  logic              tail_wr,
  input  logic [IDX_W-1:0]  tail_val,
  output logic [ADDR_W-1:0] base_q,
  output logic [IDX_W:0]    size_q,
  output logic [IDX_W-1:0]  tail_q,
  output logic              tail_accept
);
  import rxr_pkg::*;

  // Refill index is accepted only inside the ring and never beside a reconfiguration.
  assign tail_accept = tail_wr && !cfg_wr &&
                       (ring_word_t'(tail_val) < ring_word_t'(size_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      tail_q <= '0;
    end else if (cfg_wr) begin
      base_q <= cfg_base;
      size_q <= cfg_size;
      tail_q <= '0;
    end else if (tail_accept) begin
      tail_q <= tail_val;
    end
  end
endmodule

// File: rtl/rxr_head_ctrl.sv
module rxr_head_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IDX_W:0]   size_q,
  input  logic [IDX_W-1:0] tail_q,
  input  logic             store_done,
  input  logic             wb_done,
  output logic [IDX_W-1:0] head_q,
  output logic             pend_q,
  output logic             store_ok,
  output logic             store_take,
  output logic             head_adv
);
  import rxr_pkg::*;

  logic [IDX_W-1:0] head_nxt;

  assign store_ok   = !pend_q && (head_q != tail_q);
  assign store_take = store_done && store_ok && !clr;
  assign head_adv   = wb_done && pend_q && !clr;
  assign head_nxt   = IDX_W'(ring_next(ring_word_t'(head_q), ring_word_t'(size_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      head_q <= '0;
      pend_q <= 1'b0;
    end else if (head_adv) begin
      head_q <= head_nxt;
      pend_q <= 1'b0;
    end else if (store_take) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_q,
  input  logic [IDX_W:0]    size_q,
  input  logic [IDX_W-1:0]  head_q,
  input  logic [IDX_W-1:0]  tail_q,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [IDX_W-1:0]  avail_cnt,
  output logic              ring_empty
);
  import rxr_pkg::*;

  logic [63:0] addr_wide;

  assign addr_wide  = slot_addr(64'(base_q), ring_word_t'(head_q));
  assign desc_addr  = addr_wide[ADDR_W-1:0];
  assign avail_cnt  = IDX_W'(ring_gap(ring_word_t'(tail_q), ring_word_t'(head_q),
                                      ring_word_t'(size_q)));
  assign ring_empty = (head_q == tail_q);

  logic [63-ADDR_W:0] unused_hi;
  assign unused_hi = addr_wide[63:ADDR_W];
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W:0]    cfg_size,
  input  logic              tail_wr,
  input  logic [IDX_W-1:0]  tail_val,
  input  logic              store_done,
  input  logic              wb_done,
  output logic              store_ok,
  output logic              wb_pending,
  output logic              ring_empty,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [IDX_W-1:0]  avail_cnt,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W:0]    size_q;
  logic              tail_accept;
  logic              store_take;
  logic              head_adv;

  rxr_cfg_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .tail_wr(tail_wr), .tail_val(tail_val),
    .base_q(base_q), .size_q(size_q), .tail_q(tail_idx), .tail_accept(tail_accept)
  );

  rxr_head_ctrl #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .size_q(size_q), .tail_q(tail_idx),
    .store_done(store_done), .wb_done(wb_done), .head_q(head_idx),
    .pend_q(wb_pending), .store_ok(store_ok), .store_take(store_take),
    .head_adv(head_adv)
  );

  rxr_addr_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_addr (
    .base_q(base_q), .size_q(size_q), .head_q(head_idx), .tail_q(tail_idx),
    .desc_addr(desc_addr), .avail_cnt(avail_cnt), .ring_empty(ring_empty)
  );
endmodule

// File: rtl/rxr_ring_ptr_chk.sv
module rxr_ring_ptr_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             tail_wr,
  input logic [IDX_W-1:0] tail_val,
  input logic             wb_done,
  input logic             store_ok,
  input logic             wb_pending,
  input logic             ring_empty,
  input logic [IDX_W-1:0] head_idx,
  input logic [IDX_W-1:0] tail_idx,
  input logic [IDX_W:0]   size_q,
  input logic             tail_accept,
  input logic             store_take,
  input logic             head_adv
);
  // R4
  empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty |-> !store_ok);
  // R5
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pending && !wb_done && !cfg_wr |=> $stable(head_idx) && wb_pending);
  // R5
  take_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_take |=> wb_pending);
  // R6
  adv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_adv |=> !wb_pending);
  // R6
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q != '0) |-> ({1'b0, head_idx} < size_q));
  // R2
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (head_idx == '0) && (tail_idx == '0) && !wb_pending);
  // R3
  tail_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_wr && !cfg_wr && ({1'b0, tail_val} >= size_q) |=> $stable(tail_idx));
  // R3
  tail_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_accept |=> tail_idx == $past(tail_val));
endmodule

bind rxr_ring_ptr rxr_ring_ptr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .tail_wr(tail_wr), .tail_val(tail_val),
  .wb_done(wb_done), .store_ok(store_ok), .wb_pending(wb_pending),
  .ring_empty(ring_empty), .head_idx(head_idx), .tail_idx(tail_idx),
  .size_q(size_q), .tail_accept(tail_accept), .store_take(store_take),
  .head_adv(head_adv)
);

// File: tb/rxr_ring_ptr_bench.sv
module rxr_ring_ptr_bench;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [IDX_W:0]    cfg_size = '0;
  logic              tail_wr = 1'b0;
  logic [IDX_W-1:0]  tail_val = '0;
  logic              store_done = 1'b0;
  logic              wb_done = 1'b0;
  logic              store_ok, wb_pending, ring_empty;
  logic [IDX_W-1:0]  head_idx, tail_idx, avail_cnt;
  logic [ADDR_W-1:0] desc_addr;

  always #2 clk = ~clk;

  rxr_ring_ptr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_rxr_ring_ptr (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .tail_wr(tail_wr), .tail_val(tail_val),
    .store_done(store_done), .wb_done(wb_done), .store_ok(store_ok),
    .wb_pending(wb_pending), .ring_empty(ring_empty), .head_idx(head_idx),
    .tail_idx(tail_idx), .avail_cnt(avail_cnt), .desc_addr(desc_addr)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  head;
    logic [7:0]  tail;
    logic [7:0]  avail;
    logic        empty;
    logic        ok;
    logic        pend;
    logic [31:0] addr;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Reference state
  int m_head = 0, m_tail = 0, m_size = 0, m_pend = 0;
  longint m_base = 0;

  function automatic exp_t snap(int req);
    exp_t e;
    e.req   = 8'(req);
    e.head  = 8'(m_head);
    e.tail  = 8'(m_tail);
    e.avail = (m_size == 0) ? 8'd0 : 8'((m_tail + m_size - m_head) % m_size);
    e.empty = (m_head == m_tail);
    e.ok    = (m_pend == 0) && (m_head != m_tail);
    e.pend  = (m_pend != 0);
    e.addr  = 32'(m_base + longint'(m_head) * 16);
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_vec++;
    if (head_idx !== e.head || tail_idx !== e.tail || avail_cnt !== e.avail ||
        ring_empty !== e.empty || store_ok !== e.ok || wb_pending !== e.pend ||
        desc_addr !== e.addr) begin
      n_bad++;
      $display("FAIL R%0d: got head=%0d tail=%0d avail=%0d empty=%b ok=%b pend=%b addr=%h exp head=%0d tail=%0d avail=%0d empty=%b ok=%b pend=%b addr=%h",
               e.req, head_idx, tail_idx, avail_cnt, ring_empty, store_ok, wb_pending, desc_addr,
               e.head, e.tail, e.avail, e.empty, e.ok, e.pend, e.addr);
    end
  endtask

  // Driver: applies one cycle of strobes and pushes the expected state after the edge.
  task automatic step(int req, bit c, int base, int size, bit tw, int tv, bit st, bit wb);
    bit old_ok;
    @(negedge clk);
    cfg_wr = c; cfg_base = 32'(base); cfg_size = 9'(size);
    tail_wr = tw; tail_val = 8'(tv); store_done = st; wb_done = wb;
    old_ok = (m_pend == 0) && (m_head != m_tail);
    if (c) begin
      m_base = longint'(base); m_size = size; m_head = 0; m_tail = 0; m_pend = 0;
    end else begin
      if (tw && tv < m_size) m_tail = tv;
      if (m_pend != 0 && wb) begin
        m_head = (m_head + 1) % m_size; m_pend = 0;
      end else if (st && old_ok) m_pend = 1;
    end
    q.push_back(snap(req));
  endtask

  task automatic idle(int req);
    step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: samples 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare(snap(1));
    rst_n = 1'b1;
    @(negedge clk);
    compare(snap(1));

    step(2, 1, 32'h1000_0040, 8, 0, 0, 0, 0);   // R2 program ring of 8
    step(4, 0, 0, 0, 0, 0, 1, 0);               // R4 store while empty ignored
    step(3, 0, 0, 0, 1, 8, 0, 0);               // R3 tail at length rejected
    step(3, 0, 0, 0, 1, 5, 0, 0);               // R3 tail 5 accepted
    step(6, 0, 0, 0, 0, 0, 0, 1);               // R6 write-back with nothing pending
    step(5, 0, 0, 0, 0, 0, 1, 0);               // R5 store taken
    step(5, 0, 0, 0, 0, 0, 1, 0);               // R5 second store ignored
    idle(5);                                    // R5 head holds
    step(6, 0, 0, 0, 0, 0, 0, 1);               // R6 advance to 1, R7 address
    step(8, 0, 0, 0, 1, 0, 1, 0);               // R8 refill 0 plus store same cycle
    step(6, 0, 0, 0, 0, 0, 0, 1);               // R6 head 2
    for (int i = 0; i < 6; i++) begin           // R6 walk through wrap to 0
      step(7, 0, 0, 0, 0, 0, 1, 0);
      step(6, 0, 0, 0, 0, 0, 0, 1);
    end
    step(4, 0, 0, 0, 0, 0, 1, 0);               // R4 empty again, store ignored
    step(9, 1, 32'h0000_2000, 5, 1, 3, 0, 0);   // R9 cfg beats refill
    step(3, 0, 0, 0, 1, 4, 0, 0);               // R3 tail 4 of 5 accepted
    step(3, 0, 0, 0, 1, 5, 0, 0);               // R3 tail 5 rejected
    step(5, 0, 0, 0, 0, 0, 1, 0);
    step(6, 0, 0, 0, 0, 0, 0, 1);               // R7 head 1 address
    step(5, 0, 0, 0, 0, 0, 1, 0);
    step(2, 1, 32'h0000_3000, 256, 0, 0, 0, 1); // R2 cfg beats write-back
    step(3, 0, 0, 0, 1, 255, 0, 0);             // R3 top slot accepted
    for (int i = 0; i < 255; i++) begin         // R6 full-length walk
      step(6, 0, 0, 0, 0, 0, 1, 0);
      step(6, 0, 0, 0, 0, 0, 0, 1);
    end
    step(8, 0, 0, 0, 1, 0, 0, 0);               // R8 one slot across the wrap
    step(5, 0, 0, 0, 0, 0, 1, 0);
    step(6, 0, 0, 0, 0, 0, 0, 1);               // R6 wrap 255 -> 0
    idle(4);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule